// File: doc/BRIEF.md
# Masked Interleaved Channel Selector

This block takes a time-interleaved sample stream in which up to `N_CHAN` channels follow one another in fixed order, and passes on only the channels chosen by a keep mask. Each input cycle is either a sample or a frame marker. A cycle with `in_gate` high carries one sample. A cycle with `in_gate` low is a frame boundary, and the next sample after it is channel 0.

The output is a registered copy of the stream. `out_gate` marks each forwarded sample. `out_trig` repeats each frame boundary in the same register stage, and `out_valid` is its inverse. `out_err` pulses when a frame held a number of samples that does not equal the channel count.

A parameter sets how mask bits map to channels: most significant bit first or least significant bit first. The mask is captured only at frame boundaries, so a frame never mixes two masks. The stream cannot be stalled. Every input cycle is accepted, there is no ready signal, and the downstream logic must take every output cycle.

Top module: `conveyor_chan_select`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs clear: `out_gate`, `out_trig`, `out_err` and `out_data` all become 0. The channel position returns to 0, and the captured mask becomes all zeros.
- R2: Every input cycle with `in_gate` low is a frame boundary. `out_trig` is high in the cycle after it and low in the cycle after a cycle with `in_gate` high.
- R3: With `MASK_LSB_FIRST` = 0, channel k is forwarded when bit `N_CHAN-1-k` of the captured mask is 1. Bit `N_CHAN-1` therefore selects channel 0.
- R4: With `MASK_LSB_FIRST` = 1, channel k is forwarded when bit k of the captured mask is 1.
- R5: The k-th sample after a boundary, counting from 0, is channel k. Samples beyond position `N_CHAN-1` in a frame are never forwarded.
- R6: The mask used for a frame is `chan_mask` as sampled on that frame's boundary cycle. A change of `chan_mask` in the middle of a frame has no effect until the next boundary.
- R7: `out_err` is 1 for one cycle, together with `out_trig`, after a boundary that ends a run of samples whose length is neither 0 nor `N_CHAN`. After a run of exactly `N_CHAN` samples, or after two boundaries in a row, `out_err` is 0.
- R8: When a sample is forwarded, `out_data` equals that sample's `in_data` in the following cycle. Otherwise `out_data` holds its previous value.
- R9: `out_valid` is the inverse of `out_trig` in every cycle.
- R10: `out_gate` and `out_trig` are never high in the same cycle. At most `N_CHAN` samples are forwarded between two `out_trig` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DW | Sample data of the current input cycle |
| in_gate | input | 1 | 1: the cycle carries a sample; 0: the cycle is a frame boundary |
| chan_mask | input | N_CHAN | Keep mask, captured on boundary cycles |
| out_data | output | DW | Last forwarded sample |
| out_gate | output | 1 | A forwarded sample is present this cycle |
| out_trig | output | 1 | Registered frame boundary |
| out_valid | output | 1 | Inverse of `out_trig` |
| out_err | output | 1 | Frame length error pulse |

## Verification
The bench drives frames under several masks into two copies of the block, one for each bit order. Masks that keep only channel 0 or only channel 11 expose a reversed bit mapping, because under a wrong mapping the wrong slot would carry the sample. A frame that overruns to 14 samples and a frame cut short at 5 samples check the error pulse and the dropping of samples past the last channel. Two boundaries in a row must raise no error, which a design that checks any run length other than 12 would get wrong. A mask change in mid-frame and a reset in mid-frame catch a design that reads the live mask, or that keeps a stale channel position or mask after reset.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  // Mask bit order selector values
  localparam int ORDER_MSB_FIRST = 0;
  localparam int ORDER_LSB_FIRST = 1;

  // Width for a position counter that must reach n+1 (overrun marker)
  function automatic int pos_width(input int n);
    return $clog2(n + 2);
  endfunction
endpackage

// File: rtl/sel_frame_tracker.sv
module sel_frame_tracker #(
  parameter int N_CHAN = 12,
  parameter int CW     = chsel_pkg::pos_width(N_CHAN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  output logic [CW-1:0] slot,
  output logic          frame_bad
);
  localparam logic [CW-1:0] FULL = CW'(N_CHAN);
  localparam logic [CW-1:0] OVER = CW'(N_CHAN + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (!gate)       cnt_q <= '0;
    else if (cnt_q != OVER) cnt_q <= cnt_q + ONE;
  end

  assign slot      = cnt_q;
  assign frame_bad = !gate && (cnt_q != '0) && (cnt_q != FULL);
endmodule

// File: rtl/sel_mask_hold.sv
module sel_mask_hold #(
  parameter int N_CHAN = 12,
  parameter int ORDER  = chsel_pkg::ORDER_MSB_FIRST,
  parameter int CW     = chsel_pkg::pos_width(N_CHAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N_CHAN-1:0] mask_in,
  input  logic [CW-1:0]     slot,
  output logic              keep
);
  logic [N_CHAN-1:0] mask_q;
  logic [N_CHAN-1:0] by_slot;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= mask_in;
  end

  generate
    if (ORDER == chsel_pkg::ORDER_LSB_FIRST) begin : g_lsb
      assign by_slot = mask_q;
    end else begin : g_msb
      for (genvar g = 0; g < N_CHAN; g++) begin : g_rev
        assign by_slot[g] = mask_q[N_CHAN-1-g];
      end
    end
  endgenerate

  always_comb begin
    keep = 1'b0;
    for (int i = 0; i < N_CHAN; i++) begin
      if (slot == CW'(i)) keep = by_slot[i];
    end
  end
endmodule

// File: rtl/sel_out_stage.sv
module sel_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic          keep,
  input  logic          bad,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] q_data,
  output logic          q_gate,
  output logic          q_trig,
  output logic          q_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
      q_gate <= 1'b0;
      q_trig <= 1'b0;
      q_err  <= 1'b0;
    end else begin
      q_gate <= gate && keep;
      q_trig <= !gate;
      q_err  <= bad;
      if (gate && keep) q_data <= data;
    end
  end
endmodule

// File: rtl/conveyor_chan_select.sv
module conveyor_chan_select #(
  parameter int N_CHAN         = 12,
  parameter int MASK_LSB_FIRST = 0,
  parameter int DW             = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     in_data,
  input  logic              in_gate,
  input  logic [N_CHAN-1:0] chan_mask,
  output logic [DW-1:0]     out_data,
  output logic              out_gate,
  output logic              out_trig,
  output logic              out_valid,
  output logic              out_err
);
  localparam int CW = chsel_pkg::pos_width(N_CHAN);

  logic [CW-1:0] slot;
  logic          frame_bad;
  logic          keep;

  sel_frame_tracker #(.N_CHAN(N_CHAN), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .gate(in_gate), .slot(slot), .frame_bad(frame_bad)
  );

  sel_mask_hold #(.N_CHAN(N_CHAN), .ORDER(MASK_LSB_FIRST), .CW(CW)) u_mask (
    .clk(clk), .rst(rst), .load(!in_gate), .mask_in(chan_mask),
    .slot(slot), .keep(keep)
  );

  sel_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .gate(in_gate), .keep(keep), .bad(frame_bad),
    .data(in_data), .q_data(out_data), .q_gate(out_gate),
    .q_trig(out_trig), .q_err(out_err)
  );

  assign out_valid = !out_trig;
endmodule

// File: rtl/conveyor_chan_select_chk.sv
module conveyor_chan_select_chk #(
  parameter int N_CHAN = 12,
  parameter int DW     = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_gate,
  input logic [DW-1:0] out_data,
  input logic          out_gate,
  input logic          out_trig,
  input logic          out_err
);
  int fwd_cnt;

  always_ff @(posedge clk) begin
    if (rst || out_trig) fwd_cnt <= 0;
    else if (out_gate)   fwd_cnt <= fwd_cnt + 1;
  end

  assert_trig_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_trig == !$past(in_gate)));

  assert_gate_from_sample_R5: assert property (@(posedge clk) disable iff (rst)
    out_gate |-> $past(in_gate));

  assert_err_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_trig);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_gate) |-> $stable(out_data));

  assert_no_gate_trig_R10: assert property (@(posedge clk) disable iff (rst)
    !(out_gate && out_trig));

  assert_frame_limit_R10: assert property (@(posedge clk) disable iff (rst)
    out_gate |-> (fwd_cnt < N_CHAN));
endmodule

bind conveyor_chan_select conveyor_chan_select_chk #(.N_CHAN(N_CHAN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_gate(in_gate), .out_data(out_data),
  .out_gate(out_gate), .out_trig(out_trig), .out_err(out_err)
);

// File: tb/sim_conveyor_chan_select.sv
module sim_conveyor_chan_select;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int NV = 8;
  // {mask for MSB-first copy, mask for LSB-first copy, samples in frame}
  localparam logic [28:0] VEC [NV] = '{
    {12'hFFF, 12'hFFF, 5'd12},
    {12'h800, 12'h001, 5'd12},
    {12'h001, 12'h800, 5'd12},
    {12'hA5C, 12'h3C1, 5'd12},
    {12'h000, 12'hFFF, 5'd12},
    {12'hFFF, 12'h000, 5'd5},
    {12'h0F0, 12'h0F0, 5'd12},
    {12'hFFF, 12'hFFF, 5'd14}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] in_data = '0;
  logic in_gate = 1'b0;
  logic [N-1:0] m0 = '0, m1 = '0;
  logic [15:0] d0, d1;
  logic g0, g1, t0, t1, v0, v1, e0, e1;

  int checks = 0, errors = 0;
  string focus = "";

  // bench model state
  int bcnt = 0;
  logic [N-1:0] bm0 = '0, bm1 = '0;
  logic [15:0] xd0 = '0, xd1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conveyor_chan_select #(.N_CHAN(N), .MASK_LSB_FIRST(0), .DW(16)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_gate(in_gate), .chan_mask(m0),
    .out_data(d0), .out_gate(g0), .out_trig(t0), .out_valid(v0), .out_err(e0));

  conveyor_chan_select #(.N_CHAN(N), .MASK_LSB_FIRST(1), .DW(16)) u1 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_gate(in_gate), .chan_mask(m1),
    .out_data(d1), .out_gate(g1), .out_trig(t1), .out_valid(v1), .out_err(e1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, focus, act, exp);
    end
  endtask

  task automatic cyc(input logic g, input logic [15:0] d);
    logic xg0, xg1, xt, xe;
    xg0 = 1'b0; xg1 = 1'b0; xe = 1'b0;
    xt = !g;
    if (!g) begin
      xe = (bcnt != 0) && (bcnt != N);
      bm0 = m0; bm1 = m1; bcnt = 0;
    end else begin
      if (bcnt < N) begin
        xg0 = bm0[N-1-bcnt];
        xg1 = bm1[bcnt];
      end
      if (bcnt < N + 1) bcnt++;
      if (xg0) xd0 = d;
      if (xg1) xd1 = d;
    end
    in_gate = g; in_data = d;
    @(negedge clk);
    chk((bcnt > N) ? "R5" : "R3", {31'd0, g0}, {31'd0, xg0});
    chk((bcnt > N) ? "R5" : "R4", {31'd0, g1}, {31'd0, xg1});
    chk("R2", {30'd0, t1, t0}, {30'd0, xt, xt});
    chk("R9", {30'd0, v1, v0}, {30'd0, !xt, !xt});
    chk("R7", {30'd0, e1, e0}, {30'd0, xe, xe});
    chk("R8", {d1, d0}, {xd1, xd0});
  endtask

  task automatic frame(input int n, input logic [7:0] tagv);
    cyc(1'b0, 16'hFFFF);
    for (int k = 0; k < n; k++) cyc(1'b1, {tagv, 8'(k)});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_gate = 1'b1;
    repeat (2) @(negedge clk);
    bcnt = 0; bm0 = '0; bm1 = '0; xd0 = '0; xd1 = '0;
    chk("R1", {28'd0, g0, t0, e0, g1}, 32'd0);
    chk("R1", {28'd0, t1, e1, v0, v1}, 32'd3);
    chk("R1", {d1, d0}, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R6: reset leaves the captured mask at zero, so samples before any boundary are dropped
    focus = "R6 after reset";
    m0 = 12'hFFF; m1 = 12'hFFF;
    for (int k = 0; k < 3; k++) cyc(1'b1, 16'h0100 + 16'(k));
    focus = "";
    for (int i = 0; i < NV; i++) begin
      m0 = VEC[i][28:17]; m1 = VEC[i][16:5];
      frame(int'(VEC[i][4:0]), 8'(i + 1));
    end
    // R7: two boundaries in a row after a full frame raise no error
    focus = "R7 double boundary";
    m0 = 12'hFFF; m1 = 12'hFFF;
    frame(N, 8'h20);
    cyc(1'b0, 16'hFFFF);
    cyc(1'b0, 16'hFFFF);
    // R6: mid-frame mask change is ignored until the next boundary
    focus = "R6 mid-frame mask";
    m0 = 12'h000; m1 = 12'h000;
    cyc(1'b0, 16'hFFFF);
    for (int k = 0; k < 3; k++) cyc(1'b1, 16'h3000 + 16'(k));
    m0 = 12'hFFF; m1 = 12'hFFF;
    for (int k = 3; k < N; k++) cyc(1'b1, 16'h3000 + 16'(k));
    frame(N, 8'h31);
    // R1: reset in mid-frame clears position and mask
    focus = "R1 mid-frame reset";
    cyc(1'b0, 16'hFFFF);
    for (int k = 0; k < 4; k++) cyc(1'b1, 16'h4000 + 16'(k));
    do_reset();
    for (int k = 0; k < 3; k++) cyc(1'b1, 16'h4100 + 16'(k));
    frame(N, 8'h42);
    cyc(1'b0, 16'hFFFF);
    focus = "";
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule